// File: doc/BRIEF.md
# Single-Accumulator Nibble Processor

This block is a small 4-bit processor core. It has one accumulator, one carry flag and a 4-bit program counter, and it uses a Harvard organisation. The counter drives the address of an external program store. That store returns an 8-bit instruction word. The upper nibble of the word selects the operation and the lower nibble is either an immediate operand or a jump destination. Every instruction takes exactly one clock period, so a program has at most sixteen words and runs at one word per cycle.

Each operation is named by a single set bit in the upper nibble, which keeps decoding to one comparison per operation. The two clock edges do separate jobs. On the rising edge the accumulator and the carry flag take their new values. On the falling edge the counter either steps forward or loads a jump destination. This gives the program store half a period to present the next word before that word is executed. Debug outputs expose the accumulator, the flag, the counter and the current instruction word, so a program can be followed cycle by cycle.

Top module: `nib_acc_cpu`

## Requirements
- R1: The instruction word is 8 bits wide. Bits [7:4] are the operation code and bits [3:0] are the immediate operand or jump destination.
- R2: Operation code 4'b0001 sets both the accumulator and the carry flag to zero on the rising edge.
- R3: Operation code 4'b0010 adds the immediate to the accumulator on the rising edge. The accumulator keeps the low 4 bits of the sum and the carry flag takes bit 4.
- R4: Operation code 4'b0100 loads the counter with the destination on the falling edge when the carry flag is 1. When the flag is 0, the counter increments.
- R5: Operation code 4'b1000 always loads the counter with the destination on the falling edge.
- R6: The carry flag keeps its value through every operation other than the clear (R2) and the add (R3).
- R7: For any operation that is not a taken jump, the counter increments by one on the falling edge and wraps from 15 to 0.
- R8: Operation code 4'b0000, and any operation code with more than one bit set, leaves the accumulator and the flag unchanged. The counter only increments.
- R9: Driving rst_ni low clears the counter, the accumulator and the flag at once, without waiting for a clock edge.
- R10: imem_addr_o always equals pc_o, and instr_o always equals imem_data_i.
- R11: The accumulator and the flag change only on the rising edge, and the counter changes only on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock: rising edge updates the data state, falling edge updates the counter |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 4 | Address sent to the program store |
| imem_data_i | input | 8 | Instruction word returned by the program store |
| acc_o | output | 4 | Debug view of the accumulator |
| carry_o | output | 1 | Debug view of the carry flag |
| pc_o | output | 4 | Debug view of the program counter |
| instr_o | output | 8 | Debug view of the instruction word being executed |

## Verification
A wrong accumulator or flag shows up at acc_o or carry_o right after the rising edge of the same cycle. A wrong decision on the counter shows up at pc_o and imem_addr_o half a period later, on the falling edge. A corrupted flag also affects the next conditional jump, so a bad carry becomes a wrong address within one instruction. The bench checks every state output twice per cycle: once after the rising edge, when only the data state may have moved, and once after the falling edge, when the counter has moved. A fault is therefore caught in the cycle it occurs.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;
  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OP_CLR = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OP_JC  = 4'b0100;
  localparam logic [OP_W-1:0] OP_JMP = 4'b1000;

  typedef struct packed {
    logic clr;
    logic add;
    logic jc;
    logic jmp;
  } ctl_t;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nib_cpu_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [OP_W+W-1:0] instr_i,
  output ctl_t              ctl_o,
  output logic [W-1:0]      imm_o
);
  logic [OP_W-1:0] op;

  assign op    = instr_i[OP_W+W-1:W];
  assign imm_o = instr_i[W-1:0];

  // exact match only: zero or multiple set bits fall through as no-op
  always_comb begin
    ctl_o     = '0;
    ctl_o.clr = (op == OP_CLR);
    ctl_o.add = (op == OP_ADD);
    ctl_o.jc  = (op == OP_JC);
    ctl_o.jmp = (op == OP_JMP);
  end
endmodule

// File: rtl/nib_datapath.sv
module nib_datapath
  import nib_cpu_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ctl_t         ctl_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] acc_o,
  output logic         carry_o
);
  logic [W:0]   sum;
  logic [W-1:0] acc_q;
  logic         carry_q;

  assign sum = {1'b0, acc_q} + {1'b0, imm_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (ctl_i.clr) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (ctl_i.add) begin
      acc_q   <= sum[W-1:0];
      carry_q <= sum[W];
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/nib_pc.sv
module nib_pc
  import nib_cpu_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ctl_t         ctl_i,
  input  logic         carry_i,
  input  logic [W-1:0] tgt_i,
  output logic [W-1:0] pc_o
);
  logic [W-1:0] pc_q;
  logic         take;

  // carry seen here is the value latched on the preceding rising edge
  assign take = ctl_i.jmp | (ctl_i.jc & carry_i);

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (take) pc_q <= tgt_i;
    else           pc_q <= pc_q + 1'b1;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/nib_acc_cpu.sv
module nib_acc_cpu
  import nib_cpu_pkg::*;
#(
  parameter int unsigned W = 4,
  localparam int unsigned IW = OP_W + W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [W-1:0]  imem_addr_o,
  input  logic [IW-1:0] imem_data_i,
  output logic [W-1:0]  acc_o,
  output logic          carry_o,
  output logic [W-1:0]  pc_o,
  output logic [IW-1:0] instr_o
);
  ctl_t         ctl;
  logic [W-1:0] imm;
  logic [W-1:0] acc;
  logic         carry;
  logic [W-1:0] pc;

  nib_decode #(.W(W)) u_dec (
    .instr_i (imem_data_i),
    .ctl_o   (ctl),
    .imm_o   (imm)
  );

  nib_datapath #(.W(W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl),
    .imm_i   (imm),
    .acc_o   (acc),
    .carry_o (carry)
  );

  nib_pc #(.W(W)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl),
    .carry_i (carry),
    .tgt_i   (imm),
    .pc_o    (pc)
  );

  assign imem_addr_o = pc;
  assign pc_o        = pc;
  assign acc_o       = acc;
  assign carry_o     = carry;
  assign instr_o     = imem_data_i;
endmodule

// File: rtl/nib_acc_cpu_chk.sv
module nib_acc_cpu_chk #(
  parameter int unsigned W = 4,
  localparam int unsigned IW = W + 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] imem_data_i,
  input logic [W-1:0]  acc_o,
  input logic          carry_o,
  input logic [W-1:0]  pc_o
);
  logic [3:0]   op;
  logic [W-1:0] imm;
  assign op  = imem_data_i[IW-1:W];
  assign imm = imem_data_i[W-1:0];

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'b0001) |=> (acc_o == '0 && !carry_o));

  p_add_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'b0010) |=> ({carry_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(imm)})));

  p_carry_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 4'b0001 && op != 4'b0010) |=> (carry_o == $past(carry_o)));

  p_acc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 4'b0001 && op != 4'b0010) |=> (acc_o == $past(acc_o)));

  p_cond_jump_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (op == 4'b0100) |=> (pc_o == ($past(carry_o) ? $past(imm) : $past(pc_o) + 1'b1)));

  p_jump_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (op == 4'b1000) |=> (pc_o == $past(imm)));

  p_pc_step_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (op != 4'b0100 && op != 4'b1000) |=> (pc_o == $past(pc_o) + 1'b1));
endmodule

bind nib_acc_cpu nib_acc_cpu_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .imem_data_i (imem_data_i),
  .acc_o       (acc_o),
  .carry_o     (carry_o),
  .pc_o        (pc_o)
);

// File: tb/sim_nib_acc_cpu.sv
`timescale 1ns/1ps
module sim_nib_acc_cpu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] imem = 8'h00;
  logic [3:0] addr, acc, pc;
  logic       carry;
  logic [7:0] instr;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_acc = '0;
  logic [3:0] m_pc = '0;
  logic       m_c = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  nib_acc_cpu u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .imem_addr_o (addr),
    .imem_data_i (imem),
    .acc_o       (acc),
    .carry_o     (carry),
    .pc_o        (pc),
    .instr_o     (instr)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // packs {pc, carry, acc}
  function automatic logic [15:0] st(input logic [3:0] p, input logic c, input logic [3:0] a);
    return {4'h0, p, 3'b000, c, a};
  endfunction

  task automatic step(input logic [7:0] ins, input string req);
    logic [3:0] op, imm;
    logic [4:0] s;
    op  = ins[7:4];
    imm = ins[3:0];
    imem = ins;
    @(posedge clk); #1;
    if (op == 4'b0001) begin m_acc = '0; m_c = 1'b0; end
    else if (op == 4'b0010) begin s = {1'b0, m_acc} + {1'b0, imm}; m_acc = s[3:0]; m_c = s[4]; end
    // R11: data state moved, counter not yet
    chk(st(pc, carry, acc) == st(m_pc, m_c, m_acc), {req, "/R11 rise"},
        st(pc, carry, acc), st(m_pc, m_c, m_acc));
    @(negedge clk); #1;
    if (op == 4'b1000 || (op == 4'b0100 && m_c)) m_pc = imm;
    else m_pc = m_pc + 4'd1;
    chk(st(pc, carry, acc) == st(m_pc, m_c, m_acc), {req, " fall"},
        st(pc, carry, acc), st(m_pc, m_c, m_acc));
    chk(addr == pc && instr == ins, "R10", {addr, pc, instr}, {m_pc, m_pc, ins});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 16'h0, 16'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    chk(st(pc, carry, acc) == 16'h0 && addr == 4'h0, "R9 reset", st(pc, carry, acc), 16'h0);
    rst_n = 1'b1;

    // R2 R3: exhaustive add pairs from a cleared state
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        step(8'h10, "R2");
        step({4'h2, 4'(a)}, "R3");
        step({4'h2, 4'(b)}, "R3");
      end

    // R4: conditional jump with both flag values, all destinations
    for (int c = 0; c < 2; c++)
      for (int t = 0; t < 16; t++) begin
        step(8'h10, "R2");
        if (c == 1) begin step(8'h2F, "R3"); step(8'h21, "R3"); end
        else step(8'h21, "R3");
        step({4'h4, 4'(t)}, "R4");
      end

    // R5: unconditional jump to every destination
    for (int t = 0; t < 16; t++) step({4'h8, 4'(t)}, "R5");

    // R6: flag survives non-arithmetic operations
    step(8'h10, "R2"); step(8'h2F, "R3"); step(8'h21, "R3");
    step(8'h00, "R6"); step(8'h87, "R6"); step(8'h43, "R6");
    step(8'hF5, "R6"); step(8'h3A, "R6"); step(8'h65, "R6");
    step(8'h20, "R6");

    // R1 R8: every operation code with every operand from a known state
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 16; i++) begin
        step(8'h10, "R2"); step(8'h29, "R3"); step(8'h29, "R3");
        step({4'(o), 4'(i)}, "R1/R8");
      end

    // R7: increment wraps past 15
    step(8'h8E, "R5"); step(8'h00, "R7"); step(8'h00, "R7"); step(8'hC0, "R7");

    // R9: asynchronous reset in mid-run, low phase
    step(8'h2B, "R3"); step(8'h86, "R5");
    rst_n = 1'b0;
    #0.5;
    chk(st(pc, carry, acc) == 16'h0, "R9 async", st(pc, carry, acc), 16'h0);
    m_acc = '0; m_c = 1'b0; m_pc = '0;
    @(negedge clk); #1;
    rst_n = 1'b1;
    step(8'h23, "R9/R3");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule